// File: doc/BRIEF.md
# Successive-Approximation Conversion and Serial Output Controller

This block is the digital sequencer for a successive-approximation analog-to-digital converter. A single serial clock drives it, and an active-low select frames each conversion. When select drops, the block opens the sample switch for a short acquisition window. It then freezes the sample and runs a binary search, one result bit per clock. On each step it presents a trial code to an external capacitive DAC and reads back one comparator decision.

Each result bit goes out on the serial data line in the same clock step that decides it, so the word that streams out belongs to the sample in progress. The word starts with a zero null bit and then sends the most significant bit first. If the host keeps clocking, the same word is sent again least significant bit first, and after that the line holds zero. Raising select is both the end of a frame and a power-down request. It releases the data line, closes the acquisition path and discards every piece of conversion state.

Top module: `sar_serial_adc`

## Requirements
- R1: While `cs_n` is high, `sdo_oe` and `sample_en` are low at once. The first `sclk` rising edge seen with `cs_n` high clears `dac_code` to 0 and drops all frame state, so the next frame starts from the beginning.
- R2: `sample_en` goes high as soon as `cs_n` falls. It stays high until the ACQ_EDGES-th rising edge after the fall (default 2) and then stays low for the rest of the frame.
- R3: `sdo_oe` stays low until that same ACQ_EDGES-th edge, which raises it and drives a null bit of 0 on `sdo`.
- R4: At hold entry, `dac_code` presents a trial with only bit WIDTH-1 set (0x8000). At each decision edge, the bit under trial becomes 1 if `cmp_in` is high (input at or above the trial code) and 0 otherwise. `dac_code` then shows the decided upper bits plus a 1 at the next lower position.
- R5: The result goes out most significant bit first. The bit decided at rising edge ACQ_EDGES+1+(WIDTH-1-k) appears on `sdo` as bit k right after that edge, with no delay of a whole sample.
- R6: The result is a plain unsigned binary code from 0 to 2^WIDTH-1. After the last decision edge, `dac_code` holds the full result.
- R7: If clocking continues, the next WIDTH edges put result bits 0, 1, ..., WIDTH-1 on `sdo` in that order.
- R8: After the least-significant-first replay, `sdo` stays 0 with `sdo_oe` high until `cs_n` rises.
- R9: The input is sampled only once per frame. Once `sample_en` has fallen, it stays low until `cs_n` rises, so later changes at the analog input do not affect the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low frame select; high requests shutdown |
| cmp_in | input | 1 | Comparator decision: 1 when the held input is at or above `dac_code` |
| sample_en | output | 1 | High while the sample switch tracks the input |
| dac_code | output | WIDTH | Trial code presented to the capacitive DAC |
| sdo | output | 1 | Serial data, meant to be read at the falling edge of `sclk` |
| sdo_oe | output | 1 | Drive enable for `sdo`; low means the pin floats |

## Verification
The assertions take for granted that `cs_n` only changes while `sclk` is low and that every low period of `cs_n` spans at least one rising edge. They also assume `cmp_in` is a settled function of `dac_code` by the next rising edge. The bench keeps to these assumptions: it moves `cs_n` and the analog input only just after a falling edge. It also models the comparator as an ideal, instant compare against a code that it captures on rising edges while `sample_en` is high. To show the sample is taken only once, the bench rewrites the modelled input during some conversions and still expects the originally held value.

// File: rtl/sar_ctl_pkg.sv
package sar_ctl_pkg;

    typedef enum logic [2:0] {
        PH_OFF    = 3'd0,
        PH_ACQ    = 3'd1,
        PH_CONV   = 3'd2,
        PH_REPLAY = 3'd3,
        PH_TAIL   = 3'd4
    } sar_phase_e;

endpackage

// File: rtl/sar_acq_count.sv
module sar_acq_count #(
    parameter int ACQ_EDGES = 2,
    localparam int ACQ_W    = $clog2(ACQ_EDGES + 1)
) (
    input  logic [ACQ_W-1:0] cnt_q,
    output logic [ACQ_W-1:0] cnt_d,
    output logic             done
);
    always_comb begin
        cnt_d = cnt_q + 1'b1;
        done  = (cnt_d == ACQ_W'(ACQ_EDGES));
    end
endmodule

// File: rtl/sar_search_step.sv
module sar_search_step #(
    parameter int WIDTH  = 16,
    localparam int IDX_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] result_q,
    input  logic [IDX_W-1:0] idx,
    input  logic             cmp,
    output logic [WIDTH-1:0] result_d,
    output logic [WIDTH-1:0] trial_d,
    output logic             last
);
    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            result_d[i] = (i == int'(idx)) ? cmp : result_q[i];
        end
        last = (idx == '0);
        if (last) begin
            trial_d = result_d;
        end else begin
            trial_d = result_d | (WIDTH'(1) << (idx - 1'b1));
        end
    end
endmodule

// File: rtl/sar_replay_sel.sv
module sar_replay_sel #(
    parameter int WIDTH  = 16,
    localparam int IDX_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] word,
    input  logic [IDX_W-1:0] idx,
    output logic             bit_out,
    output logic             last
);
    always_comb begin
        bit_out = word[idx];
        last    = (idx == IDX_W'(WIDTH - 1));
    end
endmodule

// File: rtl/sar_serial_adc.sv
module sar_serial_adc
    import sar_ctl_pkg::*;
#(
    parameter int WIDTH     = 16,
    parameter int ACQ_EDGES = 2
) (
    input  logic             sclk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             cmp_in,
    output logic             sample_en,
    output logic [WIDTH-1:0] dac_code,
    output logic             sdo,
    output logic             sdo_oe
);
    localparam int IDX_W = $clog2(WIDTH);
    localparam int ACQ_W = $clog2(ACQ_EDGES + 1);
    localparam logic [WIDTH-1:0] MSB_TRIAL = WIDTH'(1) << (WIDTH - 1);

    typedef struct packed {
        sar_phase_e       phase;
        logic [ACQ_W-1:0] acq_cnt;
        logic [IDX_W-1:0] idx;
        logic [WIDTH-1:0] result;
        logic [WIDTH-1:0] dac;
        logic             sdo;
        logic             oe;
    } state_t;

    state_t s_q, s_d;

    logic [ACQ_W-1:0] acq_cnt_d;
    logic             acq_done;
    logic [WIDTH-1:0] search_result_d;
    logic [WIDTH-1:0] search_trial_d;
    logic             search_last;
    logic             replay_bit;
    logic             replay_last;

    sar_acq_count #(.ACQ_EDGES(ACQ_EDGES)) i_acq (
        .cnt_q (s_q.acq_cnt),
        .cnt_d (acq_cnt_d),
        .done  (acq_done)
    );

    sar_search_step #(.WIDTH(WIDTH)) i_search (
        .result_q (s_q.result),
        .idx      (s_q.idx),
        .cmp      (cmp_in),
        .result_d (search_result_d),
        .trial_d  (search_trial_d),
        .last     (search_last)
    );

    sar_replay_sel #(.WIDTH(WIDTH)) i_replay (
        .word    (s_q.result),
        .idx     (s_q.idx),
        .bit_out (replay_bit),
        .last    (replay_last)
    );

    always_comb begin
        s_d = s_q;
        if (cs_n) begin
            s_d = '0;
        end else begin
            unique case (s_q.phase)
                PH_OFF, PH_ACQ: begin
                    if (acq_done) begin
                        s_d.phase   = PH_CONV;
                        s_d.acq_cnt = '0;
                        s_d.idx     = IDX_W'(WIDTH - 1);
                        s_d.result  = '0;
                        s_d.dac     = MSB_TRIAL;
                        s_d.oe      = 1'b1;
                        s_d.sdo     = 1'b0;
                    end else begin
                        s_d.phase   = PH_ACQ;
                        s_d.acq_cnt = acq_cnt_d;
                    end
                end
                PH_CONV: begin
                    s_d.result = search_result_d;
                    s_d.sdo    = cmp_in;
                    if (search_last) begin
                        s_d.dac   = search_result_d;
                        s_d.phase = PH_REPLAY;
                        s_d.idx   = '0;
                    end else begin
                        s_d.dac = search_trial_d;
                        s_d.idx = s_q.idx - 1'b1;
                    end
                end
                PH_REPLAY: begin
                    s_d.sdo = replay_bit;
                    if (replay_last) begin
                        s_d.phase = PH_TAIL;
                    end else begin
                        s_d.idx = s_q.idx + 1'b1;
                    end
                end
                PH_TAIL: begin
                    s_d.sdo = 1'b0;
                end
                default: begin
                    s_d = '0;
                end
            endcase
        end
    end

    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sample_en = !cs_n && (s_q.phase == PH_OFF || s_q.phase == PH_ACQ);
    assign sdo_oe    = s_q.oe && !cs_n;
    assign sdo       = s_q.sdo;
    assign dac_code  = s_q.dac;

endmodule

// File: rtl/sar_serial_adc_chk.sv
module sar_serial_adc_chk #(
    parameter int WIDTH = 16
) (
    input logic             sclk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             sample_en,
    input logic [WIDTH-1:0] dac_code,
    input logic             sdo,
    input logic             sdo_oe
);
    localparam logic [WIDTH-1:0] MSB_TRIAL = WIDTH'(1) << (WIDTH - 1);

    a_r1_shutdown_quiet: assert property (@(posedge sclk) disable iff (!rst_n)
        cs_n |-> (!sdo_oe && !sample_en));

    a_r1_dac_cleared: assert property (@(posedge sclk) disable iff (!rst_n)
        cs_n |=> (dac_code == '0));

    a_r2_track_or_drive: assert property (@(posedge sclk) disable iff (!rst_n)
        !(sample_en && sdo_oe));

    a_r3_null_first: assert property (@(posedge sclk) disable iff (!rst_n)
        $rose(sdo_oe) |-> !sdo);

    a_r4_msb_trial: assert property (@(posedge sclk) disable iff (!rst_n)
        $rose(sdo_oe) |-> (dac_code == MSB_TRIAL));

    a_r9_single_sample: assert property (@(posedge sclk) disable iff (!rst_n)
        (!sample_en && !cs_n) |=> !sample_en);

endmodule

bind sar_serial_adc sar_serial_adc_chk #(.WIDTH(WIDTH)) i_chk (
    .sclk      (sclk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .sample_en (sample_en),
    .dac_code  (dac_code),
    .sdo       (sdo),
    .sdo_oe    (sdo_oe)
);

// File: tb/test_sar_serial_adc.sv
module test_sar_serial_adc;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 16;
    localparam int NVEC       = 8;

    // each entry: {rewrite input after hold, input code, expected result}
    localparam logic [32:0] VEC [NVEC] = '{
        {1'b0, 16'h0000, 16'h0000},
        {1'b0, 16'hFFFF, 16'hFFFF},
        {1'b1, 16'h8000, 16'h8000},
        {1'b1, 16'h7FFF, 16'h7FFF},
        {1'b0, 16'h1234, 16'h1234},
        {1'b1, 16'hA5A5, 16'hA5A5},
        {1'b0, 16'h0001, 16'h0001},
        {1'b1, 16'hFFFE, 16'hFFFE}
    };

    logic         sclk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cs_n = 1'b1;
    logic         cmp_in;
    logic         sample_en;
    logic [W-1:0] dac_code;
    logic         sdo;
    logic         sdo_oe;
    logic [W-1:0] vin = '0;
    logic [W-1:0] held = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) sclk = ~sclk;

    // ideal track-and-hold and comparator
    always @(posedge sclk) if (sample_en) held <= vin;
    assign cmp_in = (held >= dac_code);

    sar_serial_adc #(.WIDTH(W)) i_sar_serial_adc (
        .sclk      (sclk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .cmp_in    (cmp_in),
        .sample_en (sample_en),
        .dac_code  (dac_code),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge sclk);
        @(negedge sclk);
    endtask

    task automatic frame(input logic [W-1:0] code, input logic [W-1:0] expv, input bit disturb);
        cs_n = 1'b0;
        vin  = code;
        #1;
        chk(sample_en == 1'b1, "R2 sample_en at select fall", 32'(sample_en), 1);
        chk(sdo_oe == 1'b0, "R3 output idle at select fall", 32'(sdo_oe), 0);
        tick();
        chk(sample_en == 1'b1 && sdo_oe == 1'b0, "R2 still acquiring after edge 1",
            32'({sample_en, sdo_oe}), 32'b10);
        tick();
        chk(sdo_oe == 1'b1 && sdo == 1'b0, "R3 null bit after edge 2", 32'({sdo_oe, sdo}), 32'b10);
        chk(sample_en == 1'b0, "R2 sample_en low at hold", 32'(sample_en), 0);
        chk(dac_code == 16'h8000, "R4 first trial", 32'(dac_code), 32'h8000);
        if (disturb) vin = ~code;
        for (int k = W - 1; k >= 0; k--) begin
            logic [W-1:0] trial;
            tick();
            trial = expv & ~((W'(1) << k) - W'(1));
            if (k > 0) trial = trial | (W'(1) << (k - 1));
            chk(sdo == expv[k], "R5 msb-first bit", 32'(sdo), 32'(expv[k]));
            chk(dac_code == trial, "R4 trial code", 32'(dac_code), 32'(trial));
            chk(sample_en == 1'b0, "R9 no resample in conversion", 32'(sample_en), 0);
        end
        chk(dac_code == expv, "R6 final result", 32'(dac_code), 32'(expv));
        for (int k = 0; k < W; k++) begin
            tick();
            chk(sdo == expv[k] && sdo_oe == 1'b1, "R7 lsb-first replay", 32'(sdo), 32'(expv[k]));
        end
        for (int k = 0; k < 3; k++) begin
            tick();
            chk(sdo == 1'b0 && sdo_oe == 1'b1, "R8 zero after replay", 32'({sdo_oe, sdo}), 32'b10);
        end
        cs_n = 1'b1;
        #1;
        chk(sdo_oe == 1'b0 && sample_en == 1'b0, "R1 release on select high",
            32'({sdo_oe, sample_en}), 0);
        tick();
        chk(dac_code == '0, "R1 dac cleared", 32'(dac_code), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge sclk);
        #1;
        chk(sdo_oe == 1'b0 && dac_code == '0 && sample_en == 1'b0, "R1 reset state",
            32'({sdo_oe, sample_en, dac_code}), 0);
        tick();
        rst_n = 1'b1;
        tick();

        foreach (VEC[v]) begin
            frame(VEC[v][31:16], VEC[v][15:0], VEC[v][32]);
            tick();
        end

        // R1 and R9: abort mid-conversion, then a clean frame from scratch
        cs_n = 1'b0;
        vin  = 16'hFFFF;
        for (int k = 0; k < 8; k++) tick();
        cs_n = 1'b1;
        #1;
        chk(sdo_oe == 1'b0, "R1 abort releases output", 32'(sdo_oe), 0);
        tick();
        chk(dac_code == '0 && sample_en == 1'b0, "R1 abort drops state",
            32'({sample_en, dac_code}), 0);
        frame(16'h0F0F, 16'h0F0F, 1'b1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule